// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a slower main memory. It keeps a small direct-mapped array of one-word lines. Each line carries a valid flag, a tag and a data word. The line is chosen by the low bits of the word address, and the remaining high bits form the tag. A read that finds a valid line with a matching tag completes in the same cycle. A read that misses fetches the word from memory and replaces the line.

Writes never test for a hit. Every write takes over its line: the data and tag are stored and the valid flag is set. The write is also placed in a small first-in first-out posting queue. That queue drains to memory one request at a time. A read that misses in the array but finds its address in the queue takes the newest queued value and makes no memory trip. When the queue is full, the processor is held on a write until a slot frees.

Both sides use a request/ready handshake. A requester holds its request and its fields steady until it sees ready high at a rising edge, and the transfer completes on that edge. Read data is valid in the cycle where ready is high.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid and no memory request is active. The first read of any address therefore goes to memory.
- R2: The line index is the low INDEX_W bits of the word address, and the tag is the remaining upper bits. A read hits only when the indexed line is valid and its tag equals the address tag.
- R3: A read hit raises cpu_ready in the cycle of the request and returns the line data, without starting a memory read.
- R4: A read that misses both the array and the posting queue issues one memory read of that address. It returns mem_rdata to the processor in the cycle mem_ready is high and writes the word and tag into the line, so the next read of that address hits.
- R5: A write accepted while the queue has room completes in the cycle it is presented. It overwrites the indexed line's tag and data and sets valid, whether it hit or not. A different address with the same index then misses.
- R6: The posting queue holds up to WB_DEPTH writes. It sends them to memory in arrival order, each with its own address and data, until the queue is empty.
- R7: A write presented while WB_DEPTH writes are pending is held with cpu_ready low until an entry drains.
- R8: Once mem_req is raised, it stays high with a stable address, direction and write data until mem_ready is seen.
- R9: A read that misses the array but matches a queued address completes in the same cycle with the newest queued data for that address.
- R10: With READ_FIRST set, a pending read miss is given the memory port ahead of queued writes, so at most one write (the one already in flight) completes while the read waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes on this edge |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on reads |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory direction, 1 = write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory completes the request on this edge |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |

## Verification
A stale or mis-tagged line shows at the ports at once: cpu_ready comes in the request cycle with the wrong cpu_rdata. Or a read that should hit is delayed by a memory round trip instead. A corrupted posting queue shows up either as a memory write out of order or with the wrong data, seen on the edge it completes, or as a read-after-write forwarding miss that returns stale memory data several cycles later. A wrong occupancy count shows as a write stalled with room to spare, or one accepted into a full queue.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      PORT_IDLE = 2'd0,
      PORT_RD   = 2'd1,
      PORT_WR   = 2'd2
   } port_op_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 32,
   parameter int INDEX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int ENTRIES = 1 << INDEX_W;
   localparam int TAG_W   = ADDR_W - INDEX_W;

   generate
      if (INDEX_W < 1 || INDEX_W >= ADDR_W) begin : g_bad_index
         $error("wtc_tag_store: INDEX_W must lie in 1..ADDR_W-1");
      end
   endgenerate

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];

   logic [INDEX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0]   lk_tag, wr_tag;

   assign lk_idx = lk_addr[INDEX_W-1:0];
   assign lk_tag = lk_addr[ADDR_W-1:INDEX_W];
   assign wr_idx = wr_addr[INDEX_W-1:0];
   assign wr_tag = wr_addr[ADDR_W-1:INDEX_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_data = data_q[lk_idx];

   AST_LINE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))); // R5
endmodule

// File: rtl/wtc_write_buffer.sv
module wtc_write_buffer #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic [DATA_W-1:0] head_data,
   output logic              empty,
   output logic              full,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = PTR_W + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("wtc_write_buffer: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;
   logic [CNT_W-1:0]  cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
      end
   end

   assign head_addr = addr_q[rd_ptr];
   assign head_data = data_q[rd_ptr];

   // scan oldest to newest so the newest match is the one left standing
   always_comb begin
      lk_hit  = 1'b0;
      lk_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         logic [PTR_W-1:0] slot;
         slot = rd_ptr + PTR_W'(i);
         if ((CNT_W'(i) < cnt) && (addr_q[slot] == lk_addr)) begin
            lk_hit  = 1'b1;
            lk_data = data_q[slot];
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R6
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH)); // R6
endmodule

// File: rtl/wtc_mem_port.sv
module wtc_mem_port
   import wtc_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter bit READ_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_want,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wr_avail,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   output logic              rd_done,
   output logic              wr_done
);
   port_op_e op_q, op_d;
   logic     pick_rd, pick_wr;

   generate
      if (READ_FIRST) begin : g_read_first
         assign pick_rd = rd_want;
         assign pick_wr = wr_avail && !rd_want;
         AST_READ_JUMPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
            (op_q == PORT_IDLE) && rd_want |=> (op_q == PORT_RD)); // R10
      end else begin : g_write_first
         assign pick_wr = wr_avail;
         assign pick_rd = rd_want && !wr_avail;
      end
   endgenerate

   always_comb begin
      op_d = op_q;
      unique case (op_q)
         PORT_IDLE: begin
            if (pick_rd)      op_d = PORT_RD;
            else if (pick_wr) op_d = PORT_WR;
         end
         PORT_RD, PORT_WR: begin
            if (mem_ready) op_d = PORT_IDLE;
         end
         default: op_d = PORT_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) op_q <= PORT_IDLE;
      else        op_q <= op_d;
   end

   assign mem_req   = (op_q != PORT_IDLE);
   assign mem_we    = (op_q == PORT_WR);
   assign mem_addr  = (op_q == PORT_WR) ? wr_addr : rd_addr;
   assign mem_wdata = wr_data;
   assign rd_done   = (op_q == PORT_RD) && mem_ready;
   assign wr_done   = (op_q == PORT_WR) && mem_ready;

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata)); // R8
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 32,
   parameter int INDEX_W    = 3,
   parameter int WB_DEPTH   = 4,
   parameter bit READ_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);
   logic              ts_hit, ts_wr;
   logic [DATA_W-1:0] ts_data, ts_wdata;
   logic              wb_hit, wb_full, wb_empty, wb_push;
   logic [DATA_W-1:0] wb_data, wb_head_data;
   logic [ADDR_W-1:0] wb_head_addr;
   logic              rd_want, rd_done, wr_done;
   logic              is_read;

   assign is_read  = cpu_req && !cpu_we;
   assign wb_push  = cpu_req && cpu_we && !wb_full;
   assign rd_want  = is_read && !ts_hit && !wb_hit;
   assign ts_wr    = wb_push || rd_done;
   assign ts_wdata = cpu_we ? cpu_wdata : mem_rdata;

   assign cpu_ready = cpu_we ? wb_push : (is_read && (ts_hit || wb_hit || rd_done));
   assign cpu_rdata = ts_hit ? ts_data : (wb_hit ? wb_data : mem_rdata);

   wtc_tag_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_addr (cpu_addr),
      .lk_hit  (ts_hit),
      .lk_data (ts_data),
      .wr_en   (ts_wr),
      .wr_addr (cpu_addr),
      .wr_data (ts_wdata)
   );

   wtc_write_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wb_push),
      .push_addr (cpu_addr),
      .push_data (cpu_wdata),
      .pop       (wr_done),
      .head_addr (wb_head_addr),
      .head_data (wb_head_data),
      .empty     (wb_empty),
      .full      (wb_full),
      .lk_addr   (cpu_addr),
      .lk_hit    (wb_hit),
      .lk_data   (wb_data)
   );

   wtc_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_FIRST(READ_FIRST)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_want   (rd_want),
      .rd_addr   (cpu_addr),
      .wr_avail  (!wb_empty),
      .wr_addr   (wb_head_addr),
      .wr_data   (wb_head_data),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ready (mem_ready),
      .rd_done   (rd_done),
      .wr_done   (wr_done)
   );

   AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      is_read && ts_hit |=> !(mem_req && !mem_we)); // R3
   AST_FWD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      is_read && !ts_hit && wb_hit |-> cpu_ready); // R9
   AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done && cpu_req && !cpu_we |=> (cpu_req && !cpu_we && $stable(cpu_addr)) -> ts_hit); // R4
endmodule

// File: tb/wt_dcache_bench.sv
module wt_dcache_bench;
   localparam int AW = 10, DW = 32, IW = 3, WBD = 4, LAT = 3;
   localparam int NLINE = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_ready;
   logic [DW-1:0] cpu_rdata;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ready = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   always #4 clk = ~clk;

   wt_dcache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(IW), .WB_DEPTH(WBD)) u_wt_dcache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata));

   int n_checks = 0, n_fail = 0, wr_cnt = 0, cyc_total = 0, lat_cnt = 0;
   bit done = 0;
   logic [DW-1:0] mem_arr [1 << AW];
   logic [DW-1:0] ref_mem [1 << AW];
   bit            cv [NLINE];
   int            ct [NLINE];
   int            pend_a [$];
   logic [DW-1:0] pend_d [$];
   bit            hold_q = 0;
   logic [AW-1:0] hold_addr;
   logic          hold_we;

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // behavioural memory, fixed latency, ready driven at the falling edge
   always @(negedge clk) begin
      if (rst_n && hold_q)
         chk(mem_req && mem_addr == hold_addr && mem_we == hold_we, "R8 request held",
             DW'(mem_addr), DW'(hold_addr));
      if (mem_ready) begin
         mem_ready = 1'b0;
         lat_cnt = 0;
      end else if (rst_n && mem_req) begin
         if (lat_cnt == LAT - 1) begin
            mem_ready = 1'b1;
            mem_rdata = mem_arr[mem_addr];
         end else lat_cnt++;
      end
      hold_q    = rst_n && mem_req && !mem_ready;
      hold_addr = mem_addr;
      hold_we   = mem_we;
   end

   always @(posedge clk) begin
      if (rst_n && mem_req && mem_ready && mem_we) begin
         mem_arr[mem_addr] = mem_wdata;
         wr_cnt++;
         if (pend_a.size() == 0) chk(0, "R6 unexpected write", DW'(mem_addr), '0);
         else begin
            int            ea;
            logic [DW-1:0] ed;
            ea = pend_a.pop_front();
            ed = pend_d.pop_front();
            chk(mem_addr == AW'(ea), "R6 drain order addr", DW'(mem_addr), DW'(ea));
            chk(mem_wdata == ed, "R6 drain data", mem_wdata, ed);
         end
      end
   end

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc_total);
         summary();
      end
   end

   task automatic access(input bit we, input int a, input logic [DW-1:0] d, output int cyc);
      int            idx, tg, psz, wr0;
      bit            hit, bh;
      logic [DW-1:0] bd;
      idx = a % NLINE;
      tg  = a / NLINE;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = d;
      #2;
      hit = !we && cv[idx] && ct[idx] == tg;
      bh = 0; bd = '0;
      for (int i = 0; i < pend_a.size(); i++)
         if (pend_a[i] == a) begin bh = 1; bd = pend_d[i]; end
      psz = pend_a.size();
      wr0 = wr_cnt;
      cyc = 0;
      while (!cpu_ready && cyc < 100) begin
         @(negedge clk); #2; cyc++;
      end
      if (we) begin
         if (psz < WBD) chk(cyc == 0, "R5 write accepted at once", DW'(cyc), 0);
         else           chk(cyc > 0, "R7 write stalled on full queue", DW'(cyc), 1);
         ref_mem[a] = d; cv[idx] = 1; ct[idx] = tg;
         pend_a.push_back(a); pend_d.push_back(d);
      end else begin
         chk(cpu_rdata == ref_mem[a], "R2 read data", cpu_rdata, ref_mem[a]);
         if (hit) chk(cyc == 0, "R3 hit same cycle", DW'(cyc), 0);
         else if (bh) begin
            chk(cyc == 0, "R9 forward same cycle", DW'(cyc), 0);
            chk(cpu_rdata == bd, "R9 newest queued data", cpu_rdata, bd);
         end else begin
            chk(cyc >= LAT, "R4 miss goes to memory", DW'(cyc), DW'(LAT));
            if (psz > 0) chk(wr_cnt - wr0 <= 1, "R10 read before queued writes", DW'(wr_cnt - wr0), 1);
            cv[idx] = 1; ct[idx] = tg;
         end
      end
      @(posedge clk); #1;
      cpu_req = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int cyc;
      for (int i = 0; i < (1 << AW); i++) begin
         mem_arr[i] = 32'hC0DE0000 ^ DW'(i * 7);
         ref_mem[i] = mem_arr[i];
      end
      for (int i = 0; i < NLINE; i++) begin cv[i] = 0; ct[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(mem_req == 1'b0, "R1 no request after reset", DW'(mem_req), 0);
      chk(cpu_ready == 1'b0, "R1 idle ready low", DW'(cpu_ready), 0);

      access(0, 5, '0, cyc);                       // R1 cold miss
      chk(cyc >= LAT, "R1 first read misses", DW'(cyc), DW'(LAT));
      access(0, 5, '0, cyc);                       // R3 hit
      chk(cyc == 0, "R4 refill then hit", DW'(cyc), 0);
      access(1, 5, 32'h1111_0005, cyc);           // R5 write to a present line
      access(0, 5, '0, cyc);
      idle(20);
      access(1, 13, 32'h2222_000D, cyc);          // R5 evicts index 5
      idle(20);
      access(0, 5, '0, cyc);                       // R2 tag mismatch
      chk(cyc > 0, "R5 evicted address misses", DW'(cyc), 1);
      access(0, 13, '0, cyc);
      chk(cyc > 0, "R2 refill of 5 displaced 13", DW'(cyc), 1);

      for (int k = 0; k < 7; k++) access(1, 32 + k, 32'hAB00_0000 + DW'(k), cyc); // R7 burst
      access(1, 40, 32'h0000_0040, cyc);          // R9: 40 queued, 48 evicts it
      access(1, 48, 32'h0000_0048, cyc);
      access(0, 40, '0, cyc);
      access(0, 200, '0, cyc);                     // R10 miss behind queued writes
      idle(40);

      for (int k = 0; k < 400; k++) begin
         int a;
         a = $urandom_range(0, 47);
         access(($urandom_range(0, 2) == 0), a, $urandom(), cyc);
      end
      idle(60);
      chk(pend_a.size() == 0, "R6 queue drained", DW'(pend_a.size()), 0);
      for (int i = 0; i < 64; i++)
         chk(mem_arr[i] == ref_mem[i], "R6 memory image", mem_arr[i], ref_mem[i]);
      summary();
   end
endmodule